// File: doc/BRIEF.md
# Grayscale Clock and Row-Scan Sequencer

This block drives the scan side of a multiplexed LED panel whose column drivers generate their own PWM from a grayscale clock. For every row scan it produces a fixed number of grayscale clock pulses, 138 by default. The first 128 pulses are grayscale pulses. The last 10 are dead-time pulses, and the row address moves to the next row during that window so that the previous row does not ghost into the next one. The clock is derived from the system clock by a configurable ratio. It is registered, free of glitches, and always parks low.

A separate data-loading process shares the panel and needs a quiet moment at a frame boundary for its vertical-sync update. It raises a request level. The sequencer keeps scanning until the row address wraps back to row 0, finishes the pulse that ends that scan, parks the clock low and raises a grant. The loader then performs its update and signals completion. Scanning restarts at row 0 with a fresh pulse count. An enable input pauses the pulse stream at any point without losing position.

Top module: `gclk_row_seq`

## Requirements
- R1: Every row scan contains exactly 138 rising edges of `gclk_o`. `pulse_cnt_o` counts the rising edges already emitted in the current scan (range 0 to 137) and returns to 0 on the 138th.
- R2: `row_o` changes only on the rising edge of `gclk_o` that makes `pulse_cnt_o` equal to 129, which is the first dead-time pulse. The address is stable at all other times.
- R3: On each change, `row_o` increments by one, or returns to 0 when it was at `num_rows_i`-1 or above. A `num_rows_i` of 0 behaves as 1.
- R4: While running, `gclk_o` is high for `div_i` system cycles and low for `div_i` system cycles. A `div_i` of 0 behaves as 1.
- R5: When `enable_i` is low, `gclk_o` completes any high phase and then stays low. No rising edge is emitted, and `pulse_cnt_o` and `row_o` hold their values until `enable_i` returns high.
- R6: With `vsync_req_i` high, the scan stops at the first frame boundary that follows. A frame boundary is the end of a scan whose dead time wrapped `row_o` to 0. `vsync_grant_o` then rises while `gclk_o` is low, `row_o` is 0 and `pulse_cnt_o` is 0.
- R7: `vsync_grant_o` stays high, with `gclk_o` low, until `vsync_done_i` is sampled high. `vsync_done_i` has no effect outside the grant. After completion the grant drops on the next edge, and the first rising edge of `gclk_o` follows `div_i` cycles later.
- R8: While `rst_ni` is low, `gclk_o` is 0, `row_o` is 0, `pulse_cnt_o` is 0 and `vsync_grant_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows the pulse stream to run |
| num_rows_i | input | 6 | Number of scanned rows (0 treated as 1) |
| div_i | input | 4 | Half-period of `gclk_o` in system cycles (0 treated as 1) |
| vsync_req_i | input | 1 | Loader requests a stop at the next frame boundary |
| vsync_done_i | input | 1 | Loader has finished its vertical-sync update |
| gclk_o | output | 1 | Grayscale clock to the column drivers |
| row_o | output | 5 | Row address |
| pulse_cnt_o | output | 8 | Rising edges emitted in the current scan |
| vsync_grant_o | output | 1 | Scan parked at a frame boundary, loader may proceed |

## Verification
The hardest state to reach is the frame-boundary stop. It requires a request that is pending on exactly the scan-end pulse whose dead time wrapped the row to 0, plus the case where the clock is still in its high phase when the stop is decided. The bench sweeps every combination of one to three rows with ratios one to three. In each configuration it raises the request at an arbitrary point inside a frame. It then checks that the number of pulses between the request and the grant lands on the first boundary, and that the restart delay after completion matches the configured ratio. Pauses through the enable input are placed mid-scan so that a parked clock and held counters are observed at the outputs.

// File: rtl/gclk_seq_pkg.sv
package gclk_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_SCAN  = 2'd0,
    SEQ_PARK  = 2'd1,
    SEQ_GRANT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/gclk_div_gen.sv
module gclk_div_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             gclk_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q, div_m1;
  logic             gclk_q, tc, idle;

  assign div_m1 = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tc     = (cnt_q >= div_m1);
  assign idle   = !gclk_q && !run_i;   // park only in the low phase

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      gclk_q <= 1'b0;
    end else if (idle) begin
      cnt_q  <= '0;
    end else if (tc) begin
      cnt_q  <= '0;
      gclk_q <= ~gclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign gclk_o = gclk_q;
  assign rise_o = !gclk_q && run_i && tc;

  AST_STOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !gclk_q) |=> !gclk_q); // R5
  AST_RISE_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gclk_q) |-> $past(run_i)); // R5
endmodule

// File: rtl/gclk_pulse_ctr.sv
module gclk_pulse_ctr #(
  parameter int TOTAL  = 138,
  parameter int GS     = 128,
  parameter int PCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  output logic [PCNT_W-1:0] pcnt_o,
  output logic              dt_first_o,
  output logic              scan_end_o
);
  localparam logic [PCNT_W-1:0] LAST_P = PCNT_W'(TOTAL - 1);
  localparam logic [PCNT_W-1:0] GS_P   = PCNT_W'(GS);

  logic [PCNT_W-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pcnt_q <= '0;
    else if (rise_i) begin
      if (pcnt_q == LAST_P) pcnt_q <= '0;
      else                  pcnt_q <= pcnt_q + 1'b1;
    end
  end

  assign pcnt_o     = pcnt_q;
  assign dt_first_o = rise_i && (pcnt_q == GS_P);
  assign scan_end_o = rise_i && (pcnt_q == LAST_P);

  AST_PCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= LAST_P); // R1
  AST_PCNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pcnt_q) |-> ((pcnt_q == $past(pcnt_q) + 1'b1) ||
                          (pcnt_q == '0 && $past(pcnt_q) == LAST_P))); // R1
endmodule

// File: rtl/gclk_row_ctr.sv
module gclk_row_ctr #(
  parameter int ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  input  logic [ROW_W:0]   num_rows_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W:0]   last_row;
  logic             wrap;

  assign last_row = (num_rows_i == '0) ? '0 : num_rows_i - 1'b1;
  assign wrap     = ({1'b0, row_q} >= last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        row_q <= '0;
    else if (advance_i) row_q <= wrap ? '0 : row_q + 1'b1;
  end

  assign row_o = row_q;

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_q) |-> (row_q == '0 || row_q == $past(row_q) + 1'b1)); // R3
  AST_ROW_NEEDS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_q) |-> $past(advance_i)); // R2
endmodule

// File: rtl/gclk_sync_fsm.sv
module gclk_sync_fsm
  import gclk_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic scan_end_i,
  input  logic row_zero_i,
  input  logic gclk_i,
  input  logic req_i,
  input  logic done_i,
  output logic run_o,
  output logic grant_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_SCAN:  if (scan_end_i && req_i && row_zero_i) state_d = SEQ_PARK;
      SEQ_PARK:  if (!gclk_i)                           state_d = SEQ_GRANT;
      SEQ_GRANT: if (done_i)                            state_d = SEQ_SCAN;
      default:                                          state_d = SEQ_SCAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_SCAN;
    else         state_q <= state_d;
  end

  assign run_o   = (state_q == SEQ_SCAN) && enable_i;
  assign grant_o = (state_q == SEQ_GRANT);

  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !done_i) |=> grant_o); // R7
  AST_GRANT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && done_i) |=> !grant_o); // R7
  AST_GRANT_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !gclk_i); // R6
endmodule

// File: rtl/gclk_row_seq.sv
module gclk_row_seq #(
  parameter int GS_PULSES = 128,
  parameter int DT_PULSES = 10,
  parameter int MAX_ROWS  = 32,
  parameter int DIV_W     = 4,
  localparam int TOTAL    = GS_PULSES + DT_PULSES,
  localparam int PCNT_W   = $clog2(TOTAL),
  localparam int ROW_W    = $clog2(MAX_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ROW_W:0]    num_rows_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              vsync_req_i,
  input  logic              vsync_done_i,
  output logic              gclk_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [PCNT_W-1:0] pulse_cnt_o,
  output logic              vsync_grant_o
);
  localparam logic [PCNT_W-1:0] DT1_P = PCNT_W'(GS_PULSES + 1);

  logic run, rise, dt_first, scan_end;

  gclk_div_gen #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_i),
    .gclk_o(gclk_o),
    .rise_o(rise)
  );

  gclk_pulse_ctr #(.TOTAL(TOTAL), .GS(GS_PULSES), .PCNT_W(PCNT_W)) u_pcnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .pcnt_o    (pulse_cnt_o),
    .dt_first_o(dt_first),
    .scan_end_o(scan_end)
  );

  gclk_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (dt_first),
    .num_rows_i(num_rows_i),
    .row_o     (row_o)
  );

  gclk_sync_fsm u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .scan_end_i(scan_end),
    .row_zero_i(row_o == '0),
    .gclk_i    (gclk_o),
    .req_i     (vsync_req_i),
    .done_i    (vsync_done_i),
    .run_o     (run),
    .grant_o   (vsync_grant_o)
  );

  AST_ROW_IN_DEADTIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(row_o) |-> (pulse_cnt_o == DT1_P && $rose(gclk_o))); // R2
  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_grant_o |-> (row_o == '0 && pulse_cnt_o == '0)); // R6
  AST_NO_RISE_IN_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_grant_o |=> !$rose(gclk_o)); // R7
endmodule

// File: tb/gclk_row_seq_tb.sv
module gclk_row_seq_tb;
  localparam int GS = 128;
  localparam int DT = 10;
  localparam int TOT = GS + DT;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic [5:0] num_rows_i = 6'd1;
  logic [3:0] div_i = 4'd1;
  logic       vsync_req_i = 1'b0;
  logic       vsync_done_i = 1'b0;
  logic       gclk_o;
  logic [4:0] row_o;
  logic [7:0] pulse_cnt_o;
  logic       vsync_grant_o;

  gclk_row_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .num_rows_i(num_rows_i),
    .div_i(div_i), .vsync_req_i(vsync_req_i), .vsync_done_i(vsync_done_i),
    .gclk_o(gclk_o), .row_o(row_o), .pulse_cnt_o(pulse_cnt_o), .vsync_grant_o(vsync_grant_o)
  );

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int cur_n = 1, cur_d = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t n=%0d d=%0d actual=%0d expected=%0d", tag, $time, cur_n, cur_d, act, exp);
    end
  endtask

  // reference model driven from port observations
  int  exp_cnt = 0, exp_row = 0, rises_total = 0, since = 0, cyc = 0, last_rise = -1;
  bit  have_chg = 0;
  logic prev_g = 1'b0;
  int  prev_row = 0;

  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      exp_cnt = 0; exp_row = 0; rises_total = 0; since = 0; have_chg = 0;
      last_rise = -1; prev_g = 1'b0; prev_row = 0;
    end else begin
      bit rise;
      rise = gclk_o && !prev_g;
      if (!enable_i || vsync_grant_o) last_rise = -1;
      if (rise) begin
        rises_total++;
        since++;
        if (last_rise >= 0) chk(cyc - last_rise == 2 * cur_d, "R4 period", cyc - last_rise, 2 * cur_d);
        last_rise = cyc;
        if (exp_cnt + 1 == GS + 1) exp_row = (exp_row + 1 >= cur_n) ? 0 : exp_row + 1;
        exp_cnt = (exp_cnt + 1 == TOT) ? 0 : exp_cnt + 1;
      end
      if (int'(row_o) != prev_row) begin
        chk(rise && pulse_cnt_o == 8'(GS + 1), "R2 row change off first dead-time pulse", pulse_cnt_o, GS + 1);
        if (have_chg) chk(since == TOT, "R1 pulses per row", since, TOT);
        have_chg = 1; since = 0;
      end
      chk(int'(pulse_cnt_o) == exp_cnt, "R1 pulse count", pulse_cnt_o, exp_cnt);
      chk(int'(row_o) == exp_row, "R3 row address", row_o, exp_row);
      if (vsync_grant_o) chk(!gclk_o, "R6 gclk low in grant", gclk_o, 0);
      prev_g = gclk_o;
      prev_row = int'(row_o);
    end
  end

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk_i); #1;
    end
  endtask

  task automatic run_cfg(input int n, input int d);
    int ra, held_cnt, held_row, w;
    cur_n = n; cur_d = d;
    rst_ni = 1'b0; enable_i = 1'b1; vsync_req_i = 1'b0; vsync_done_i = 1'b0;
    num_rows_i = 6'(n); div_i = 4'(d);
    step(3);
    chk(!gclk_o && row_o == 0 && pulse_cnt_o == 0 && !vsync_grant_o, "R8 reset state",
        {gclk_o, row_o, pulse_cnt_o, vsync_grant_o}, 0);
    rst_ni = 1'b1;
    step(TOT * 2 * d * n + 97 * d);
    // done outside grant ignored
    vsync_done_i = 1'b1; step(1); vsync_done_i = 1'b0;
    chk(!vsync_grant_o, "R7 stray done ignored", vsync_grant_o, 0);
    // pause mid-scan
    enable_i = 1'b0;
    step(2 * d + 2);
    held_cnt = pulse_cnt_o; held_row = row_o;
    chk(!gclk_o, "R5 parked low", gclk_o, 0);
    step(25);
    chk(!gclk_o && int'(pulse_cnt_o) == held_cnt && int'(row_o) == held_row, "R5 hold during pause",
        pulse_cnt_o, held_cnt);
    enable_i = 1'b1;
    step(53 * d + 11 * n);
    // frame-boundary stop
    vsync_req_i = 1'b1;
    ra = rises_total;
    w = 0;
    while (!vsync_grant_o && w < 4 * TOT * 2 * d * n + 100) begin step(1); w++; end
    chk(vsync_grant_o, "R6 grant reached", vsync_grant_o, 1);
    chk(rises_total - ra > 0 && rises_total - ra <= TOT * n, "R6 first boundary", rises_total - ra, TOT * n);
    chk(row_o == 0 && pulse_cnt_o == 0, "R6 boundary position", {row_o, pulse_cnt_o}, 0);
    step(20);
    chk(vsync_grant_o && !gclk_o && pulse_cnt_o == 0, "R7 grant held", vsync_grant_o, 1);
    vsync_req_i = 1'b0; vsync_done_i = 1'b1;
    step(1);
    vsync_done_i = 1'b0;
    chk(!vsync_grant_o, "R7 grant drops", vsync_grant_o, 0);
    for (int i = 1; i < d; i++) begin
      step(1);
      chk(!gclk_o, "R7 restart delay", gclk_o, 0);
    end
    step(1);
    chk(gclk_o && pulse_cnt_o == 1 && row_o == 0, "R7 restart at row 0", pulse_cnt_o, 1);
    step(TOT * 2 * d + 17);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int n = 1; n <= 3; n++)
      for (int d = 1; d <= 3; d++)
        run_cfg(n, d);
    // zero values behave as one
    cur_n = 1; cur_d = 1;
    rst_ni = 1'b0; num_rows_i = 6'd0; div_i = 4'd0; step(2); rst_ni = 1'b1;
    step(TOT * 3 + 5);
    chk(row_o == 0, "R3 zero rows as one", row_o, 0);
    report();
  end

  initial begin
    #(1900000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule